// File: doc/BRIEF.md
# Unified SECDED Encoder/Decoder with Fault Injection

This block protects a data word with a single-error-correcting, double-error-detecting code. Each clock, a mode input picks the operation. In encode mode the block takes a `DATA_W`-bit word and produces a codeword made of the data, Hamming check bits and one overall parity bit. In decode mode it takes a received codeword, corrects a single flipped bit, and reports whether it saw a single or a double error. The mode may differ from one cycle to the next, and every word is processed in the mode that was sampled with it.

A fault injector helps test the error handling that follows the block. It can flip one bit, or two neighbouring bits, of each encoded result. The flipped position steps forward by one on every cycle that injection stays active, so a stream of encoded words covers every bit of the codeword in turn. Trailing register stages can be added through `PIPE_STAGES` to shorten the logic path. The error flags travel through the same stages as the data they describe.

Top module: `secded_unit`

## Requirements
- R1: With `modeSel`=0 the block encodes. Codeword bit 0 gives even parity over the whole codeword. Each bit at an index 2^k (k≥0) is the XOR of all bits at indices ≥1 whose index has bit k set. Data bit j sits at the j-th index, counted upward from 3, that is not a power of two. In this mode `dataOut`, `sglErr` and `dblErr` are 0.
- R2: With `modeSel`=1 the block decodes and `codeOut` is 0. A valid codeword gives its data bits on `dataOut` with both flags 0.
- R3: A word sampled at one rising edge appears at the outputs after 1+`PIPE_STAGES` further rising edges, for a latency of 2+`PIPE_STAGES` cycles. The mode may change every cycle, and each word follows its own mode.
- R4: A decoded codeword with one flipped bit at any index, including the parity bit 0, gives the corrected data with `sglErr`=1 and `dblErr`=0.
- R5: A decoded codeword with two flipped bits gives `dblErr`=1 and `sglErr`=0. `dataOut` then carries the received data bits uncorrected.
- R6: `injSel` 2'b01 flips codeword bit p of the encoded result. 2'b10 flips bits p and (p+1) mod `CW_W`. 2'b00 and 2'b11 flip nothing.
- R7: The position p is 0 for the first word with active injection after reset or after a word with no injection. It rises by one for each following word with active injection, in either mode, and wraps from `CW_W`-1 to 0. Injection never changes the decode outputs.
- R8: `rstIn` at level `RST_LEVEL` clears all outputs to 0 at once, without waiting for a clock edge, and sets the injection position back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstIn | input | 1 | Asynchronous reset, active at `RST_LEVEL` |
| modeSel | input | 1 | 0 = encode, 1 = decode |
| injSel | input | 2 | Fault injection: 00 none, 01 one bit, 10 two bits, 11 none |
| dataIn | input | DATA_W | Word to encode |
| codeOut | output | CW_W | Encoded word, after any injected faults |
| codeIn | input | CW_W | Received codeword to decode |
| dataOut | output | DATA_W | Decoded, corrected data |
| sglErr | output | 1 | A correctable single error was found |
| dblErr | output | 1 | An uncorrectable double error was found |

## Verification
The bench flips every codeword index in turn, including the overall parity bit. A design that treats a zero syndrome with bad parity as a double error, or that corrects the wrong index, shows the wrong data or flags at those positions. It runs injection for longer than one codeword length, in both single and double modes, to catch a position counter that does not wrap or a neighbour bit that falls off the top end. It also alternates the mode on every cycle and interleaves decode-mode injection, which exposes flags that lag their data and a counter that stalls or restarts when the mode changes. An asynchronous reset in the middle of traffic must clear the outputs before the next edge.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // number of Hamming check bits needed for a given data width
  function automatic int checkBits(input int dataW);
    int r;
    r = 0;
    while ((1 << r) < dataW + r + 1) r++;
    return r;
  endfunction

  // codeword index of data bit j: j-th non-power-of-two index from 3 upward
  function automatic int dataIndex(input int j);
    int p;
    int n;
    p = 3;
    n = 0;
    while (1) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) return p;
        n++;
      end
      p++;
    end
  endfunction

  typedef struct packed {
    logic decode;
    logic injOne;
    logic injTwo;
  } ctrlStrobe_t;

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
#(
  parameter int CW_W = 13,
  localparam int POS_W = $clog2(CW_W)
) (
  input  logic             clk,
  input  logic             rstAct,
  input  logic             modeSel,
  input  logic [1:0]       injSel,
  output ctrlStrobe_t      strb,
  output logic [POS_W-1:0] injPos
);

  logic       modeR;
  logic [1:0] injR;

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      modeR <= 1'b0;
      injR  <= 2'b00;
    end else begin
      modeR <= modeSel;
      injR  <= injSel;
    end
  end

  always_comb begin
    strb.decode = modeR;
    strb.injOne = (injR == 2'b01);
    strb.injTwo = (injR == 2'b10);
  end

  // position steps once per active word, cleared by any idle word
  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      injPos <= '0;
    end else if (strb.injOne || strb.injTwo) begin
      injPos <= (injPos == POS_W'(CW_W - 1)) ? '0 : injPos + 1'b1;
    end else begin
      injPos <= '0;
    end
  end

endmodule

// File: rtl/secded_dp.sv
module secded_dp
  import secded_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PIPE_STAGES = 1,
  localparam int CHK_W = checkBits(DATA_W),
  localparam int CW_W  = DATA_W + CHK_W + 1,
  localparam int POS_W = $clog2(CW_W),
  localparam int PK_W  = CW_W + DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstAct,
  input  ctrlStrobe_t       strb,
  input  logic [POS_W-1:0]  injPos,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CW_W-1:0]   codeIn,
  output logic [CW_W-1:0]   codeOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              sglErr,
  output logic              dblErr
);

  logic [DATA_W-1:0] dReg;
  logic [CW_W-1:0]   cReg;

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      dReg <= '0;
      cReg <= '0;
    end else begin
      dReg <= dataIn;
      cReg <= codeIn;
    end
  end

  // encode path
  logic [CW_W-1:0] encWord;
  logic            encPar;

  always_comb begin
    encWord = '0;
    for (int j = 0; j < DATA_W; j++) encWord[dataIndex(j)] = dReg[j];
    for (int k = 0; k < CHK_W; k++) begin
      encPar = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (p[k]) encPar = encPar ^ encWord[p];
      end
      encWord[1 << k] = encPar;
    end
    encWord[0] = ^encWord[CW_W-1:1];
  end

  // injection mask
  logic [CW_W-1:0] flipMask;
  int              nextIdx;

  always_comb begin
    nextIdx = (int'(injPos) == CW_W - 1) ? 0 : int'(injPos) + 1;
    for (int p = 0; p < CW_W; p++) begin
      flipMask[p] = ((strb.injOne || strb.injTwo) && p == int'(injPos)) ||
                    (strb.injTwo && p == nextIdx);
    end
  end

  // decode path
  logic [CHK_W-1:0]  syn;
  logic              parBad;
  logic [CW_W-1:0]   fixWord;
  logic [DATA_W-1:0] decData;
  logic              decSgl;
  logic              decDbl;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cReg[p]) syn = syn ^ CHK_W'(p);
    end
    parBad  = ^cReg;
    fixWord = cReg;
    decSgl  = 1'b0;
    decDbl  = 1'b0;
    if (parBad) begin
      if (int'(syn) < CW_W) begin
        decSgl = 1'b1;
        for (int p = 0; p < CW_W; p++) begin
          if (p == int'(syn)) fixWord[p] = ~cReg[p];
        end
      end else begin
        decDbl = 1'b1;
      end
    end else if (syn != '0) begin
      decDbl = 1'b1;
    end
    for (int j = 0; j < DATA_W; j++) decData[j] = fixWord[dataIndex(j)];
  end

  // shared result register plus trailing stages
  logic [PK_W-1:0] result;
  logic [PK_W-1:0] stg [PIPE_STAGES+1];

  assign result = strb.decode ? {{CW_W{1'b0}}, decData, decSgl, decDbl}
                              : {encWord ^ flipMask, {DATA_W{1'b0}}, 2'b00};

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      for (int i = 0; i <= PIPE_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= result;
      for (int i = 1; i <= PIPE_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign {codeOut, dataOut, sglErr, dblErr} = stg[PIPE_STAGES];

endmodule

// File: rtl/secded_unit.sv
module secded_unit
  import secded_pkg::*;
#(
  parameter int   DATA_W      = 8,
  parameter int   PIPE_STAGES = 1,
  parameter logic RST_LEVEL   = 1'b0,
  localparam int  CW_W  = DATA_W + checkBits(DATA_W) + 1,
  localparam int  POS_W = $clog2(CW_W)
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              modeSel,
  input  logic [1:0]        injSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CW_W-1:0]   codeOut,
  input  logic [CW_W-1:0]   codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              sglErr,
  output logic              dblErr
);

  logic             rstAct;
  ctrlStrobe_t      strb;
  logic [POS_W-1:0] injPos;

  assign rstAct = (rstIn == RST_LEVEL);

  secded_ctrl #(.CW_W(CW_W)) ctrl_i (
    .clk    (clk),
    .rstAct (rstAct),
    .modeSel(modeSel),
    .injSel (injSel),
    .strb   (strb),
    .injPos (injPos)
  );

  secded_dp #(.DATA_W(DATA_W), .PIPE_STAGES(PIPE_STAGES)) dp_i (
    .clk    (clk),
    .rstAct (rstAct),
    .strb   (strb),
    .injPos (injPos),
    .dataIn (dataIn),
    .codeIn (codeIn),
    .codeOut(codeOut),
    .dataOut(dataOut),
    .sglErr (sglErr),
    .dblErr (dblErr)
  );

endmodule

// File: rtl/secded_chk.sv
module secded_chk #(
  parameter int DATA_W      = 8,
  parameter int CW_W        = 13,
  parameter int PIPE_STAGES = 1
) (
  input logic              clk,
  input logic              rstAct,
  input logic              modeSel,
  input logic [1:0]        injSel,
  input logic [CW_W-1:0]   codeOut,
  input logic [DATA_W-1:0] dataOut,
  input logic              sglErr,
  input logic              dblErr
);

  // delay line of {mode, injection}; tap PIPE_STAGES+1 lines up with outputs
  logic [2:0] dly [PIPE_STAGES+2];
  logic       dMode;
  logic [1:0] dInj;

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      for (int i = 0; i < PIPE_STAGES + 2; i++) dly[i] <= '0;
    end else begin
      dly[0] <= {modeSel, injSel};
      for (int i = 1; i < PIPE_STAGES + 2; i++) dly[i] <= dly[i-1];
    end
  end

  assign {dMode, dInj} = dly[PIPE_STAGES+1];

  a_r1_enc_quiet: assert property (@(posedge clk) disable iff (rstAct)
    !dMode |-> (dataOut == '0 && !sglErr && !dblErr));

  a_r1_enc_parity: assert property (@(posedge clk) disable iff (rstAct)
    (!dMode && (dInj == 2'b00 || dInj == 2'b11)) |-> (^codeOut == 1'b0));

  a_r2_dec_code_zero: assert property (@(posedge clk) disable iff (rstAct)
    dMode |-> (codeOut == '0));

  a_r6_single_odd: assert property (@(posedge clk) disable iff (rstAct)
    (!dMode && dInj == 2'b01) |-> (^codeOut == 1'b1));

  a_r6_double_even: assert property (@(posedge clk) disable iff (rstAct)
    (!dMode && dInj == 2'b10) |-> (^codeOut == 1'b0));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rstAct)
    $onehot0({sglErr, dblErr}));

endmodule

bind secded_unit secded_chk #(
  .DATA_W(DATA_W), .CW_W(CW_W), .PIPE_STAGES(PIPE_STAGES)
) chk_i (
  .clk    (clk),
  .rstAct (rstAct),
  .modeSel(modeSel),
  .injSel (injSel),
  .codeOut(codeOut),
  .dataOut(dataOut),
  .sglErr (sglErr),
  .dblErr (dblErr)
);

// File: tb/secded_unit_tb_top.sv
`timescale 1ns/1ps
module secded_unit_tb_top;

  localparam int DW   = 8;
  localparam int PIPE = 1;

  function automatic int tbChk(input int w);
    int r;
    r = 0;
    while ((2 ** r) < w + r + 1) r = r + 1;
    return r;
  endfunction

  localparam int CW  = DW + tbChk(DW) + 1;
  localparam int PKW = CW + DW + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeSel = 1'b0;
  logic [1:0]    injSel = 2'b00;
  logic [DW-1:0] dataIn = '0;
  logic [CW-1:0] codeIn = '0;
  logic [CW-1:0] codeOut;
  logic [DW-1:0] dataOut;
  logic          sglErr;
  logic          dblErr;

  always #2 clk = ~clk;

  secded_unit #(.DATA_W(DW), .PIPE_STAGES(PIPE), .RST_LEVEL(1'b0)) dut_i (
    .clk(clk), .rstIn(rstN), .modeSel(modeSel), .injSel(injSel),
    .dataIn(dataIn), .codeOut(codeOut), .codeIn(codeIn),
    .dataOut(dataOut), .sglErr(sglErr), .dblErr(dblErr)
  );

  int nChk = 0;
  int nFail = 0;
  int injCnt = 0;
  bit finished = 0;
  logic [PKW-1:0] expQ[$];
  string tagQ[$];

  function automatic bit isPow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // behavioural codeword builder
  function automatic logic [CW-1:0] benc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int i = 3; i < CW; i++) begin
      if (!isPow2(i)) begin
        c[i] = d[j];
        j = j + 1;
      end
    end
    for (int b = 1; b < CW; b = b * 2) begin
      logic x;
      x = 1'b0;
      for (int i = 1; i < CW; i++) if ((i & b) != 0 && i != b) x = x ^ c[i];
      c[b] = x;
    end
    c[0] = 1'b0;
    for (int i = 1; i < CW; i++) c[0] = c[0] ^ c[i];
    return c;
  endfunction

  function automatic logic [DW-1:0] bext(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    j = 0;
    d = '0;
    for (int i = 3; i < CW; i++) begin
      if (!isPow2(i)) begin
        d[j] = c[i];
        j = j + 1;
      end
    end
    return d;
  endfunction

  // decode by search: valid word, or one flip away from a valid word
  function automatic logic [PKW-1:0] bdec(input logic [CW-1:0] c);
    logic [CW-1:0] t;
    if (benc(bext(c)) == c) return {{CW{1'b0}}, bext(c), 2'b00};
    for (int i = 0; i < CW; i++) begin
      t = c ^ (CW'(1) << i);
      if (benc(bext(t)) == t) return {{CW{1'b0}}, bext(t), 2'b10};
    end
    return {{CW{1'b0}}, bext(c), 2'b01};
  endfunction

  task automatic compareNow();
    logic [PKW-1:0] e;
    logic [PKW-1:0] a;
    string t;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    a = {codeOut, dataOut, sglErr, dblErr};
    nChk++;
    if (a !== e) begin
      nFail++;
      $display("FAIL %s: code/data/sgl/dbl actual %h/%h/%b/%b expected %h/%h/%b/%b",
               t, a[PKW-1 -: CW], a[DW+1:2], a[1], a[0],
               e[PKW-1 -: CW], e[DW+1:2], e[1], e[0]);
    end
  endtask

  task automatic prefill(input string t);
    for (int i = 0; i < PIPE + 2; i++) begin
      expQ.push_back('0);
      tagQ.push_back(t);
    end
  endtask

  task automatic step(input logic m, input logic [1:0] inj,
                      input logic [DW-1:0] d, input logic [CW-1:0] c,
                      input string t);
    logic [PKW-1:0] e;
    logic [CW-1:0]  mask;
    int pos;
    @(negedge clk);
    compareNow();
    modeSel = m;
    injSel  = inj;
    dataIn  = d;
    codeIn  = c;
    mask = '0;
    pos  = 0;
    if (inj == 2'b01 || inj == 2'b10) begin
      pos = injCnt;
      injCnt = (injCnt + 1) % CW;
      mask[pos] = 1'b1;
      if (inj == 2'b10) mask[(pos + 1) % CW] = 1'b1;
    end else begin
      injCnt = 0;
    end
    if (m == 1'b0) e = {benc(d) ^ mask, {DW{1'b0}}, 2'b00};
    else e = bdec(c);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic checkZero(input string t);
    nChk++;
    if ({codeOut, dataOut, sglErr, dblErr} !== '0) begin
      nFail++;
      $display("FAIL %s: outputs in reset actual %h/%h/%b/%b expected all zero",
               t, codeOut, dataOut, sglErr, dblErr);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [CW-1:0] w;

    // R8: reset state
    #7;
    checkZero("R8");
    @(negedge clk);
    rstN = 1'b1;
    prefill("R8");

    // R1: plain encoding
    for (int i = 0; i < 20; i++) step(1'b0, 2'b00, DW'($urandom), '0, "R1");
    step(1'b0, 2'b00, '1, '0, "R1");

    // R2: clean decoding
    for (int i = 0; i < 20; i++) begin
      d = DW'($urandom);
      step(1'b1, 2'b00, '0, benc(d), "R2");
    end

    // R3: mode toggles each cycle
    for (int i = 0; i < 24; i++) begin
      d = DW'($urandom);
      step(i[0], 2'b00, d, benc(~d), "R3");
    end

    // R4: one flip at every index, parity bit included
    for (int i = 0; i < CW; i++) begin
      d = DW'($urandom);
      step(1'b1, 2'b00, '0, benc(d) ^ (CW'(1) << i), "R4");
    end

    // R5: two flips
    for (int i = 0; i < CW; i++) begin
      for (int k = i + 1; k < CW; k += 3) begin
        d = DW'($urandom);
        step(1'b1, 2'b00, '0, benc(d) ^ (CW'(1) << i) ^ (CW'(1) << k), "R5");
      end
    end

    // R6/R7: single injection across a wrap
    d = 8'hA5;
    for (int i = 0; i < CW + 3; i++) step(1'b0, 2'b01, d, '0, "R7");
    // R6: value 11 injects nothing and clears position
    for (int i = 0; i < 4; i++) step(1'b0, 2'b11, d, '0, "R6");
    // R6: double injection, neighbour wraps at top index
    for (int i = 0; i < CW + 2; i++) step(1'b0, 2'b10, 8'h3C, '0, "R6");
    step(1'b0, 2'b00, 8'h3C, '0, "R6");
    // R7: decode words with injection advance position but stay clean
    for (int i = 0; i < 5; i++) begin
      d = DW'($urandom);
      step(1'b1, 2'b01, '0, benc(d), "R7");
    end
    for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 8'h96, '0, "R7");
    // R7: decode of injected stream, loop the pattern by hand
    for (int i = 0; i < 3; i++) begin
      w = benc(8'h5A) ^ (CW'(1) << (i + 2));
      step(1'b1, 2'b00, '0, w, "R4");
    end

    // R8: asynchronous reset in the middle of traffic
    step(1'b0, 2'b01, 8'hFF, '0, "R8");
    step(1'b1, 2'b00, '0, benc(8'h11) ^ CW'(3), "R8");
    @(negedge clk);
    #1;
    rstN = 1'b0;
    modeSel = 1'b0;
    injSel = 2'b00;
    dataIn = '0;
    codeIn = '0;
    #0.5;
    checkZero("R8");
    @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
    tagQ.delete();
    injCnt = 0;
    prefill("R8");
    for (int i = 0; i < 3; i++) step(1'b0, 2'b01, 8'h0F, '0, "R8");

    // drain
    for (int i = 0; i < PIPE + 2; i++) step(1'b0, 2'b00, '0, '0, "R3");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule